// File: doc/BRIEF.md
# Decoupled Iterative Multiply/Divide Unit

This block is a multiply/divide coprocessor that sits beside the main integer ALU. The core hands it two unsigned operands and an operation code. The core does not wait for the answer. The unit works through the operation iteratively and handles several shift-add or shift-subtract steps in every core clock cycle, while the core goes on with unrelated work.

Results land in two result registers. HI holds the upper half of a product or the remainder of a division. LO holds the lower half of a product or the quotient. The core reads them later with a move-from request that selects one of the two registers. If a move-from request arrives while an operation is still in flight, the unit raises a stall, and the requester must hold until the stall drops. A new issue while the unit is busy abandons the running operation and starts the new one from scratch.

Top module: `mdu_unit`

## Requirements
- R1: After reset, `busy` and `stall` are low, and both HI and LO read as zero.
- R2: With `issue_div`=0 (multiply), on completion HI holds bits [2W-1:W] and LO holds bits [W-1:0] of the unsigned product `opa`*`opb`, where W is `DATA_W`.
- R3: With `issue_div`=1 (divide) and a nonzero divisor, on completion LO holds the unsigned quotient `opa`/`opb` and HI holds the remainder `opa`%`opb`.
- R4: A divide with `opb`=0 takes the normal latency and leaves LO at all ones and HI equal to the dividend `opa`.
- R5: `busy` is high in the cycle after an issue and stays high for exactly `DATA_W/STEPS` cycles. HI and LO take the new result on the same clock edge at which `busy` falls. `DATA_W` must be a multiple of `STEPS`.
- R6: `stall` is high exactly when `rd_req` is high while `busy` is high. A move-from request to an idle unit never stalls.
- R7: HI and LO keep their previous values during an operation until its final step, and keep them while the unit is idle with no issue.
- R8: An issue while `busy` is high discards the running operation and restarts with full latency on the new operands. This also holds when the issue coincides with the old operation's final step: the old result never reaches HI or LO.
- R9: `rd_data` shows HI when `rd_sel_hi`=1 and LO when `rd_sel_hi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Start a new operation this cycle |
| issue_div | input | 1 | Operation: 0 multiply, 1 divide |
| opa | input | DATA_W | Multiplicand or dividend |
| opb | input | DATA_W | Multiplier or divisor |
| rd_req | input | 1 | Move-from request from the core |
| rd_sel_hi | input | 1 | Register select for the move-from: 1 HI, 0 LO |
| rd_data | output | DATA_W | Selected result register |
| busy | output | 1 | Operation in flight |
| stall | output | 1 | Requester must hold: move-from while busy |

## Verification
The bench builds the unit with `DATA_W`=6 and `STEPS`=3, so every operation lasts two cycles. At that size every operand pair, including every zero divisor, can be run through both multiply and divide and compared with plain integer arithmetic. The short latency also puts the abort corners within easy reach: an issue one cycle after another, and an issue that lands exactly on the final step. The stall window can then be counted cycle by cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic {
        MDU_MUL = 1'b0,
        MDU_DIV = 1'b1
    } mdu_op_e;

endpackage

// File: rtl/mdu_step.sv
// One iteration of the shared engine: a shift-add multiply step or a
// restoring divide step, chosen by the operation.
module mdu_step
    import mdu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  mdu_op_e             op,
    input  logic [DATA_W-1:0]   hi_i,
    input  logic [DATA_W-1:0]   lo_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   hi_o,
    output logic [DATA_W-1:0]   lo_o
);
    localparam int XW = DATA_W + 1;

    logic [XW-1:0] mul_sum;
    logic [XW-1:0] div_part;
    logic [XW-1:0] div_diff;
    logic          div_ge;

    always_comb begin
        // multiply: add multiplicand when the low bit is set, then shift right
        mul_sum  = {1'b0, hi_i} + (lo_i[0] ? {1'b0, b_i} : '0);
        // divide: bring the next dividend bit into the partial remainder
        div_part = {hi_i, lo_i[DATA_W-1]};
        div_ge   = (div_part >= {1'b0, b_i});
        div_diff = div_part - {1'b0, b_i};

        if (op == MDU_DIV) begin
            hi_o = div_ge ? div_diff[DATA_W-1:0] : div_part[DATA_W-1:0];
            lo_o = {lo_i[DATA_W-2:0], div_ge};
        end else begin
            hi_o = mul_sum[XW-1:1];
            lo_o = {mul_sum[0], lo_i[DATA_W-1:1]};
        end
    end

endmodule

// File: rtl/mdu_engine.sv
// Iterative engine: STEPS chained step slices per cycle, DATA_W steps total.
module mdu_engine
    import mdu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEPS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  mdu_op_e             start_op,
    input  logic [DATA_W-1:0]   start_a,
    input  logic [DATA_W-1:0]   start_b,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   res_hi,
    output logic [DATA_W-1:0]   res_lo
);
    localparam int NCYC = DATA_W / STEPS;
    localparam int CW   = (NCYC > 1) ? $clog2(NCYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(NCYC - 1);

    typedef struct packed {
        logic              busy;
        mdu_op_e           op;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] b;
        logic [CW-1:0]     cnt;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [DATA_W-1:0] chain_hi [STEPS+1];
    logic [DATA_W-1:0] chain_lo [STEPS+1];

    assign chain_hi[0] = eng_q.hi;
    assign chain_lo[0] = eng_q.lo;

    for (genvar s = 0; s < STEPS; s++) begin : g_slice
        mdu_step #(.DATA_W(DATA_W)) u_step (
            .op   (eng_q.op),
            .hi_i (chain_hi[s]),
            .lo_i (chain_lo[s]),
            .b_i  (eng_q.b),
            .hi_o (chain_hi[s+1]),
            .lo_o (chain_lo[s+1])
        );
    end

    logic last_cyc;

    always_comb begin
        eng_d    = eng_q;
        last_cyc = eng_q.busy && (eng_q.cnt == LAST);
        if (start) begin
            eng_d.busy = 1'b1;
            eng_d.op   = start_op;
            eng_d.hi   = '0;
            eng_d.lo   = start_a;
            eng_d.b    = start_b;
            eng_d.cnt  = '0;
        end else if (eng_q.busy) begin
            eng_d.hi  = chain_hi[STEPS];
            eng_d.lo  = chain_lo[STEPS];
            eng_d.cnt = eng_q.cnt + 1'b1;
            if (last_cyc) begin
                eng_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o = eng_q.busy;
    assign done_o = last_cyc && !start;
    assign res_hi = chain_hi[STEPS];
    assign res_lo = chain_lo[STEPS];

endmodule

// File: rtl/mdu_unit.sv
// Decoupled multiply/divide unit with HI/LO result registers and read interlock.
module mdu_unit
    import mdu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEPS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_vld,
    input  logic                issue_div,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                rd_req,
    input  logic                rd_sel_hi,
    output logic [DATA_W-1:0]   rd_data,
    output logic                busy,
    output logic                stall
);
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } res_t;

    res_t res_d, res_q;

    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_hi;
    logic [DATA_W-1:0] eng_lo;
    mdu_op_e           issue_op;
    logic [DATA_W-1:0] hi_w;
    logic [DATA_W-1:0] lo_w;

    assign issue_op = issue_div ? MDU_DIV : MDU_MUL;

    mdu_engine #(.DATA_W(DATA_W), .STEPS(STEPS)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (issue_vld),
        .start_op (issue_op),
        .start_a  (opa),
        .start_b  (opb),
        .busy_o   (eng_busy),
        .done_o   (eng_done),
        .res_hi   (eng_hi),
        .res_lo   (eng_lo)
    );

    always_comb begin
        res_d = res_q;
        if (eng_done) begin
            res_d.hi = eng_hi;
            res_d.lo = eng_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hi_w    = res_q.hi;
    assign lo_w    = res_q.lo;
    assign rd_data = rd_sel_hi ? hi_w : lo_w;
    assign busy    = eng_busy;
    assign stall   = eng_busy && rd_req;

endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk #(
    parameter int DATA_W = 32,
    parameter int STEPS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_vld,
    input logic              rd_req,
    input logic              busy,
    input logic              stall,
    input logic [DATA_W-1:0] hi_w,
    input logic [DATA_W-1:0] lo_w
);
    localparam int NCYC = DATA_W / STEPS;

    int run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (issue_vld) begin
            run_cnt <= 1;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> busy);

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt <= NCYC));

    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt == NCYC && !issue_vld) |=> !busy);

    p_stall_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (busy && rd_req));

    p_stall_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_req) |-> stall);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue_vld) |=> ($stable(hi_w) && $stable(lo_w)));

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_cnt < NCYC) |=> ($stable(hi_w) && $stable(lo_w)));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && issue_vld) |=> (busy && $stable(hi_w) && $stable(lo_w)));

endmodule

bind mdu_unit mdu_unit_chk #(.DATA_W(DATA_W), .STEPS(STEPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_vld (issue_vld),
    .rd_req    (rd_req),
    .busy      (busy),
    .stall     (stall),
    .hi_w      (hi_w),
    .lo_w      (lo_w)
);

// File: tb/mdu_unit_bench.sv
`timescale 1ns/1ps
module mdu_unit_bench;
    localparam int W    = 6;
    localparam int ST   = 3;
    localparam int NCYC = W / ST;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         issue_vld, issue_div, rd_req, rd_sel_hi;
    logic [W-1:0] opa, opb, rd_data;
    logic         busy, stall;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    mdu_unit #(.DATA_W(W), .STEPS(ST)) u_mdu_unit (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_div(issue_div),
        .opa(opa), .opb(opb), .rd_req(rd_req), .rd_sel_hi(rd_sel_hi),
        .rd_data(rd_data), .busy(busy), .stall(stall)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_res(output int hi, output int lo);
        rd_sel_hi = 1'b1; #1; hi = int'(rd_data);
        rd_sel_hi = 1'b0; #1; lo = int'(rd_data);
    endtask

    function automatic int exp_hi(input logic d, input int a, input int b);
        if (d) return (b == 0) ? a : (a % b);
        return ((a * b) >> W) & MASK;
    endfunction

    function automatic int exp_lo(input logic d, input int a, input int b);
        if (d) return (b == 0) ? MASK : (a / b);
        return (a * b) & MASK;
    endfunction

    task automatic issue(input logic d, input int a, input int b);
        issue_vld = 1'b1; issue_div = d; opa = W'(a); opb = W'(b);
    endtask

    // issue at the next edge, wait for completion, check results
    task automatic run_op(input logic d, input int a, input int b, input string req);
        int h, l;
        @(negedge clk); issue(d, a, b);
        @(negedge clk); issue_vld = 1'b0;
        repeat (NCYC) @(negedge clk);
        read_res(h, l);
        check({req, " hi"}, h, exp_hi(d, a, b));
        check({req, " lo"}, l, exp_lo(d, a, b));
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, l, cnt;
        rst_n = 1'b0; issue_vld = 1'b0; issue_div = 1'b0;
        opa = '0; opb = '0; rd_req = 1'b0; rd_sel_hi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_res(h, l);
        check("R1 busy", int'(busy), 0);
        check("R1 stall", int'(stall), 0);
        check("R1 hi", h, 0);
        check("R1 lo", l, 0);

        // R2 R3 R4 R9 exhaustive sweep over all operand pairs
        for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
                run_op(1'b0, a, b, "R2 R9 mul");
                run_op(1'b1, a, b, (b == 0) ? "R4 div0" : "R3 R9 div");
            end
        end

        // R5 R6 latency and stall window
        @(negedge clk); rd_req = 1'b1; #1;
        check("R6 idle no stall", int'(stall), 0);
        issue(1'b0, 45, 39);
        @(negedge clk); issue_vld = 1'b0;
        cnt = 0;
        while (busy && cnt < 50) begin
            check("R6 stall while busy", int'(stall), 1);
            cnt++;
            @(negedge clk);
        end
        check("R5 busy cycles", cnt, NCYC);
        check("R6 stall clear", int'(stall), 0);
        rd_req = 1'b0;
        read_res(h, l);
        check("R5 R2 hi at fall", h, exp_hi(1'b0, 45, 39));
        check("R5 R2 lo at fall", l, exp_lo(1'b0, 45, 39));

        // R7 R8 abort on the cycle after an issue
        run_op(1'b0, 7, 9, "R2 setup");
        @(negedge clk); issue(1'b0, 5, 6);
        @(negedge clk); issue(1'b1, 50, 7);
        @(negedge clk); issue_vld = 1'b0;
        read_res(h, l);
        check("R7 hi held mid-op", h, exp_hi(1'b0, 7, 9));
        check("R7 lo held mid-op", l, exp_lo(1'b0, 7, 9));
        check("R8 busy after restart", int'(busy), 1);
        repeat (NCYC - 1) @(negedge clk);
        check("R8 still busy full latency", int'(busy), 1);
        @(negedge clk);
        read_res(h, l);
        check("R8 restarted hi", h, 50 % 7);
        check("R8 restarted lo", l, 50 / 7);

        // R8 issue coinciding with final step discards the old result
        run_op(1'b0, 7, 9, "R2 setup");
        @(negedge clk); issue(1'b0, 5, 6);
        @(negedge clk); issue_vld = 1'b0;
        repeat (NCYC - 1) @(negedge clk);
        issue(1'b1, 61, 4);
        @(negedge clk); issue_vld = 1'b0;
        read_res(h, l);
        check("R8 busy on coincident issue", int'(busy), 1);
        check("R8 old hi discarded", h, exp_hi(1'b0, 7, 9));
        check("R8 old lo discarded", l, exp_lo(1'b0, 7, 9));
        repeat (NCYC) @(negedge clk);
        read_res(h, l);
        check("R8 new hi", h, 61 % 4);
        check("R8 new lo", l, 61 / 4);

        // R7 idle hold over several cycles
        repeat (5) @(negedge clk);
        read_res(h, l);
        check("R7 idle hi", h, 61 % 4);
        check("R7 idle lo", l, 61 / 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule